// File: doc/BRIEF.md
# I2C FIFO Threshold and Drain Event Generator

This block watches the two byte FIFOs of an I2C controller: the transmit FIFO, which the host fills and the bus side empties, and the receive FIFO, which the bus side fills and the host empties. It compares each FIFO's fill level with a threshold that software programs. It also compares the bytes still owed by the current transfer with that threshold. From these comparisons it raises one-cycle event pulses that tell the host when to move a burst of bytes.

A ready event means a full burst of threshold size can be moved. A drain event means the rest of the transfer is smaller than the threshold, so the last few bytes are handed over at once and are not left stuck below the threshold. The block holds only the level counters, a remaining-byte counter and a small state machine. The storage arrays and the bit shifting sit next to it.

The state machine has three states: `ST_IDLE`, `ST_TX_RUN` and `ST_RX_RUN`. The transitions are:

- START_TX: `ST_IDLE` moves to `ST_TX_RUN` on a start with a non-zero length and the transmit direction.
- START_RX: `ST_IDLE` moves to `ST_RX_RUN` on a start with a non-zero length and the receive direction.
- TX_DONE: `ST_TX_RUN` returns to `ST_IDLE` once the remaining count is zero.
- RX_DONE: `ST_RX_RUN` returns to `ST_IDLE` once the remaining count is zero and the receive FIFO is empty.

Top module: `fifo_thresh_events`

## Requirements
- R1: After reset both levels are 0, `xfer_busy` is 0 and all four event outputs are 0.
- R2: The transmit threshold is `thresh_cfg[5:0] + 1` and the receive threshold is `thresh_cfg[13:8] + 1`, so each lies in 1..64. The thresholds are read from the input on every cycle.
- R3: An accepted push raises a level by one and an accepted pop lowers it by one, one cycle after the strobe. A push into a full FIFO (level = DEPTH) is ignored, even when a pop arrives in the same cycle. A pop from an empty FIFO is ignored.
- R4: `tx_clr` or `rx_clr` sets that FIFO's level to 0 on the next cycle. The clear wins over a push or pop in the same cycle, and that push or pop is not accepted.
- R5: In START_TX or START_RX, a start in `ST_IDLE` with a non-zero `xfer_len` loads the remaining count and raises `xfer_busy` on the next cycle. A start with length 0, or any start while busy, is ignored.
- R6: The remaining count drops by one for each accepted `tx_pop` in `ST_TX_RUN` and for each accepted `rx_push` in `ST_RX_RUN`. It never goes below 0.
- R7: Let the transmit condition be: state `ST_TX_RUN`, transmit level below the threshold, and need = remaining − transmit level, with need at least the threshold. `tx_ready_ev` pulses for one cycle, one cycle after the cycle in which this condition first becomes true.
- R8: `tx_drain_ev` pulses the same way when, in `ST_TX_RUN`, the transmit level is below the threshold and 0 < need < threshold.
- R9: `rx_ready_ev` pulses the same way when, in `ST_RX_RUN`, the receive level is at least the receive threshold.
- R10: `rx_drain_ev` pulses the same way when, in `ST_RX_RUN`, the remaining count is 0 and 0 < receive level < receive threshold.
- R11: TX_DONE and RX_DONE clear `xfer_busy` one cycle after their condition holds.
- R12: `depth_code` is a constant n such that DEPTH = 8 << n. It is 1 for the default depth of 16.
- R13: At most one event output is high in any cycle. An event is high only if the block was busy in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thresh_cfg | input | 16 | Threshold fields: [5:0] transmit−1, [13:8] receive−1 |
| xfer_len | input | CNT_W | Byte count of the next transfer |
| xfer_start | input | 1 | Start strobe for a transfer |
| dir_rx | input | 1 | 1 = receive transfer, 0 = transmit transfer |
| tx_push | input | 1 | Host writes a byte into the transmit FIFO |
| tx_pop | input | 1 | Bus side takes a byte from the transmit FIFO |
| rx_push | input | 1 | Bus side puts a byte into the receive FIFO |
| rx_pop | input | 1 | Host reads a byte from the receive FIFO |
| tx_clr | input | 1 | Empty the transmit FIFO |
| rx_clr | input | 1 | Empty the receive FIFO |
| tx_ready_ev | output | 1 | Transmit burst request pulse |
| tx_drain_ev | output | 1 | Transmit tail request pulse |
| rx_ready_ev | output | 1 | Receive burst available pulse |
| rx_drain_ev | output | 1 | Receive tail available pulse |
| tx_level | output | LW | Transmit FIFO fill level |
| rx_level | output | LW | Receive FIFO fill level |
| xfer_busy | output | 1 | A transfer is in progress |
| depth_code | output | 4 | Encoded FIFO size n, with depth 8 << n |

## Verification
The assertions take for granted that reset is applied before the first use and that `thresh_cfg` is stable while a transfer runs. Under these conditions an edge-detected event cannot fire twice in a row or out of a run state. The stimulus changes the thresholds only while the block is idle, and at most once per directed phase. Strobes are applied freely, including pushes into a full FIFO, pops from an empty one, clears colliding with strobes, and starts while busy. A seeded pseudo-random phase mixes all inputs, keeps clears rare, and keeps the threshold fixed.

// File: rtl/fte_pkg.sv
package fte_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TX_RUN = 2'd1,
        ST_RX_RUN = 2'd2
    } fte_state_e;
endpackage

// File: rtl/fte_level_ctr.sv
module fte_level_ctr #(
    parameter int DEPTH = 16,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    output logic          push_ok,
    output logic          pop_ok,
    output logic [LW-1:0] level
);
    logic [LW-1:0] level_q;

    always_comb begin
        push_ok = push && !clr && (level_q != LW'(DEPTH));
        pop_ok  = pop  && !clr && (level_q != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            level_q <= '0;
        end else begin
            unique case ({push_ok, pop_ok})
                2'b10:   level_q <= level_q + LW'(1);
                2'b01:   level_q <= level_q - LW'(1);
                default: level_q <= level_q;
            endcase
        end
    end

    assign level = level_q;
endmodule

// File: rtl/fte_xfer_fsm.sv
module fte_xfer_fsm
    import fte_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    input  logic             dir_rx,
    input  logic             tx_take,
    input  logic             rx_take,
    input  logic             rx_empty,
    output fte_state_e       state,
    output logic [CNT_W-1:0] remain
);
    fte_state_e       state_q, state_d;
    logic [CNT_W-1:0] remain_q, remain_d;
    logic             launch;

    assign launch = (state_q == ST_IDLE) && start && (len != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
        end else begin
            state_q  <= state_d;
            remain_q <= remain_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        remain_d = remain_q;
        unique case (state_q)
            ST_IDLE: begin
                if (launch) begin
                    state_d  = dir_rx ? ST_RX_RUN : ST_TX_RUN;
                    remain_d = len;
                end
            end
            ST_TX_RUN: begin
                if (remain_q == '0)
                    state_d = ST_IDLE;
                else if (tx_take)
                    remain_d = remain_q - CNT_W'(1);
            end
            ST_RX_RUN: begin
                if (remain_q == '0) begin
                    if (rx_empty)
                        state_d = ST_IDLE;
                end else if (rx_take) begin
                    remain_d = remain_q - CNT_W'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign state  = state_q;
    assign remain = remain_q;
endmodule

// File: rtl/fte_event_gen.sv
module fte_event_gen
    import fte_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LW    = 5,
    localparam int XW   = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fte_state_e       state,
    input  logic [CNT_W-1:0] remain,
    input  logic [LW-1:0]    tx_level,
    input  logic [LW-1:0]    rx_level,
    input  logic [5:0]       tx_field,
    input  logic [5:0]       rx_field,
    output logic [3:0]       events
);
    logic [XW-1:0] rem_x, txl_x, rxl_x, thr_tx, thr_rx, need;
    logic [3:0]    cond, cond_q, ev_q;
    logic          tx_run, rx_run, tx_room, tx_owed;

    always_comb begin
        rem_x   = XW'(remain);
        txl_x   = XW'(tx_level);
        rxl_x   = XW'(rx_level);
        thr_tx  = XW'(tx_field) + XW'(1);
        thr_rx  = XW'(rx_field) + XW'(1);
        tx_run  = (state == ST_TX_RUN);
        rx_run  = (state == ST_RX_RUN);
        tx_room = txl_x < thr_tx;
        tx_owed = rem_x > txl_x;
        need    = tx_owed ? (rem_x - txl_x) : '0;
        cond[0] = tx_run && tx_room && tx_owed && (need >= thr_tx);
        cond[1] = tx_run && tx_room && tx_owed && (need <  thr_tx);
        cond[2] = rx_run && (rxl_x >= thr_rx);
        cond[3] = rx_run && (rem_x == '0) && (rxl_x != '0) && (rxl_x < thr_rx);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_q <= '0;
            ev_q   <= '0;
        end else begin
            cond_q <= cond;
            ev_q   <= cond & ~cond_q;
        end
    end

    assign events = ev_q;
endmodule

// File: rtl/fifo_thresh_events.sv
module fifo_thresh_events
    import fte_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 16,
    localparam int LW = $clog2(DEPTH + 1),
    localparam int DEPTH_CODE = $clog2(DEPTH) - 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [15:0]      thresh_cfg,
    input  logic [CNT_W-1:0] xfer_len,
    input  logic             xfer_start,
    input  logic             dir_rx,
    input  logic             tx_push,
    input  logic             tx_pop,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             tx_clr,
    input  logic             rx_clr,
    output logic             tx_ready_ev,
    output logic             tx_drain_ev,
    output logic             rx_ready_ev,
    output logic             rx_drain_ev,
    output logic [LW-1:0]    tx_level,
    output logic [LW-1:0]    rx_level,
    output logic             xfer_busy,
    output logic [3:0]       depth_code
);
    fte_state_e       state;
    logic [CNT_W-1:0] remain;
    logic [3:0]       events;
    logic             tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;

    fte_level_ctr #(.DEPTH(DEPTH)) u_tx_lvl (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push), .pop(tx_pop),
        .push_ok(tx_push_ok), .pop_ok(tx_pop_ok), .level(tx_level)
    );

    fte_level_ctr #(.DEPTH(DEPTH)) u_rx_lvl (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push), .pop(rx_pop),
        .push_ok(rx_push_ok), .pop_ok(rx_pop_ok), .level(rx_level)
    );

    fte_xfer_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(xfer_start), .len(xfer_len),
        .dir_rx(dir_rx), .tx_take(tx_pop_ok), .rx_take(rx_push_ok),
        .rx_empty(rx_level == '0), .state(state), .remain(remain)
    );

    fte_event_gen #(.CNT_W(CNT_W), .LW(LW)) u_evt (
        .clk(clk), .rst_n(rst_n), .state(state), .remain(remain),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_field(thresh_cfg[5:0]), .rx_field(thresh_cfg[13:8]),
        .events(events)
    );

    assign tx_ready_ev = events[0];
    assign tx_drain_ev = events[1];
    assign rx_ready_ev = events[2];
    assign rx_drain_ev = events[3];
    assign xfer_busy   = (state != ST_IDLE);
    assign depth_code  = 4'(DEPTH_CODE);
endmodule

// File: rtl/fte_checker.sv
module fte_checker #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 16,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_clr,
    input logic             rx_clr,
    input logic             xfer_start,
    input logic [CNT_W-1:0] xfer_len,
    input logic             xfer_busy,
    input logic [LW-1:0]    tx_level,
    input logic [LW-1:0]    rx_level,
    input logic [3:0]       evs
);
    p_tx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= LW'(DEPTH));
    p_rx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= LW'(DEPTH));
    p_tx_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clr |=> (tx_level == '0));
    p_rx_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clr |=> (rx_level == '0));
    p_zero_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_busy && xfer_start && xfer_len == '0) |=> !xfer_busy);
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evs[0] |=> !evs[0]);
    p_exclusive_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(evs));
    p_quiet_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (evs != '0) |-> $past(xfer_busy));
endmodule

bind fifo_thresh_events fte_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_clr(tx_clr), .rx_clr(rx_clr),
    .xfer_start(xfer_start), .xfer_len(xfer_len), .xfer_busy(xfer_busy),
    .tx_level(tx_level), .rx_level(rx_level),
    .evs({rx_drain_ev, rx_ready_ev, tx_drain_ev, tx_ready_ev})
);

// File: tb/fifo_thresh_events_tb_top.sv
`timescale 1ns/1ps
module fifo_thresh_events_tb_top;
    localparam int DEPTH = 16;
    localparam int LW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] thresh_cfg = '0;
    logic [15:0] xfer_len = '0;
    logic xfer_start = 0, dir_rx = 0, tx_push = 0, tx_pop = 0;
    logic rx_push = 0, rx_pop = 0, tx_clr = 0, rx_clr = 0;
    logic tx_ready_ev, tx_drain_ev, rx_ready_ev, rx_drain_ev, xfer_busy;
    logic [LW-1:0] tx_level, rx_level;
    logic [3:0] depth_code;

    int n_checks = 0, n_fail = 0;
    bit done = 0, model_on = 0;
    int seen_tr = 0, seen_td = 0, seen_rr = 0, seen_rd = 0;

    // behavioural model state
    int m_txl = 0, m_rxl = 0, m_rem = 0, m_st = 0;
    bit p_tr = 0, p_td = 0, p_rr = 0, p_rd = 0;
    bit e_tr = 0, e_td = 0, e_rr = 0, e_rd = 0;

    always #10 clk = ~clk;

    fifo_thresh_events #(.DEPTH(DEPTH), .CNT_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .thresh_cfg(thresh_cfg), .xfer_len(xfer_len),
        .xfer_start(xfer_start), .dir_rx(dir_rx), .tx_push(tx_push), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_pop(rx_pop), .tx_clr(tx_clr), .rx_clr(rx_clr),
        .tx_ready_ev(tx_ready_ev), .tx_drain_ev(tx_drain_ev),
        .rx_ready_ev(rx_ready_ev), .rx_drain_ev(rx_drain_ev),
        .tx_level(tx_level), .rx_level(rx_level), .xfer_busy(xfer_busy),
        .depth_code(depth_code)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // model of R2..R11, advanced on every clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_txl = 0; m_rxl = 0; m_rem = 0; m_st = 0;
            p_tr = 0; p_td = 0; p_rr = 0; p_rd = 0;
            e_tr = 0; e_td = 0; e_rr = 0; e_rd = 0;
        end else begin
            int thr_t, thr_r, need, n_txl, n_rxl, n_rem, n_st;
            bit c_tr, c_td, c_rr, c_rd, tpush_ok, tpop_ok, rpush_ok, rpop_ok;
            thr_t = int'(thresh_cfg[5:0]) + 1;
            thr_r = int'(thresh_cfg[13:8]) + 1;
            need  = m_rem - m_txl;
            c_tr = (m_st == 1) && (m_txl < thr_t) && (need > 0) && (need >= thr_t);
            c_td = (m_st == 1) && (m_txl < thr_t) && (need > 0) && (need < thr_t);
            c_rr = (m_st == 2) && (m_rxl >= thr_r);
            c_rd = (m_st == 2) && (m_rem == 0) && (m_rxl > 0) && (m_rxl < thr_r);
            e_tr = c_tr && !p_tr; e_td = c_td && !p_td;
            e_rr = c_rr && !p_rr; e_rd = c_rd && !p_rd;
            p_tr = c_tr; p_td = c_td; p_rr = c_rr; p_rd = c_rd;
            tpush_ok = tx_push && !tx_clr && m_txl < DEPTH;
            tpop_ok  = tx_pop  && !tx_clr && m_txl > 0;
            rpush_ok = rx_push && !rx_clr && m_rxl < DEPTH;
            rpop_ok  = rx_pop  && !rx_clr && m_rxl > 0;
            n_txl = tx_clr ? 0 : m_txl + int'(tpush_ok) - int'(tpop_ok);
            n_rxl = rx_clr ? 0 : m_rxl + int'(rpush_ok) - int'(rpop_ok);
            n_rem = m_rem; n_st = m_st;
            if (m_st == 0) begin
                if (xfer_start && xfer_len != 0) begin
                    n_st = dir_rx ? 2 : 1; n_rem = int'(xfer_len);
                end
            end else if (m_st == 1) begin
                if (m_rem == 0) n_st = 0;
                else if (tpop_ok) n_rem = m_rem - 1;
            end else begin
                if (m_rem == 0) begin
                    if (m_rxl == 0) n_st = 0;
                end else if (rpush_ok) n_rem = m_rem - 1;
            end
            m_txl = n_txl; m_rxl = n_rxl; m_rem = n_rem; m_st = n_st;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (model_on && rst_n && !done) begin
            chk("R3/R4 tx_level", int'(tx_level), m_txl);
            chk("R3/R4 rx_level", int'(rx_level), m_rxl);
            chk("R5/R6/R11 xfer_busy", int'(xfer_busy), int'(m_st != 0));
            chk("R7 tx_ready_ev", int'(tx_ready_ev), int'(e_tr));
            chk("R8 tx_drain_ev", int'(tx_drain_ev), int'(e_td));
            chk("R9 rx_ready_ev", int'(rx_ready_ev), int'(e_rr));
            chk("R10 rx_drain_ev", int'(rx_drain_ev), int'(e_rd));
            chk("R13 one event at most",
                int'(tx_ready_ev) + int'(tx_drain_ev) + int'(rx_ready_ev) + int'(rx_drain_ev) <= 1, 1);
            seen_tr += int'(tx_ready_ev); seen_td += int'(tx_drain_ev);
            seen_rr += int'(rx_ready_ev); seen_rd += int'(rx_drain_ev);
        end
    end

    task automatic drive(input bit tp, input bit tpo, input bit rp, input bit rpo,
                         input bit tc, input bit rc, input bit st);
        tx_push = tp; tx_pop = tpo; rx_push = rp; rx_pop = rpo;
        tx_clr = tc; rx_clr = rc; xfer_start = st;
        @(negedge clk);
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
        tx_clr = 0; rx_clr = 0; xfer_start = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        finish_run();
    end

    initial begin
        int r;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx_level", int'(tx_level), 0);
        chk("R1 rx_level", int'(rx_level), 0);
        chk("R1 busy", int'(xfer_busy), 0);
        chk("R1 events", int'({tx_ready_ev, tx_drain_ev, rx_ready_ev, rx_drain_ev}), 0);
        // R12 size code: 16 = 8 << 1
        chk("R12 depth_code", int'(depth_code), 1);
        model_on = 1;
        // R2 transmit threshold 4, receive threshold 3
        thresh_cfg = 16'h0203;
        // R3 overflow and underflow
        for (int i = 0; i < DEPTH + 2; i++) drive(1, 0, 1, 0, 0, 0, 0);
        chk("R3 tx full", int'(tx_level), DEPTH);
        drive(1, 1, 0, 0, 0, 0, 0);
        chk("R3 push while full ignored", int'(tx_level), DEPTH - 1);
        // R4 clear beats push
        drive(1, 0, 1, 0, 1, 1, 0);
        chk("R4 clear tx", int'(tx_level), 0);
        chk("R4 clear rx", int'(rx_level), 0);
        drive(0, 1, 0, 1, 0, 0, 0);
        chk("R3 pop from empty", int'(tx_level), 0);
        // R5 zero length ignored
        xfer_len = 0; dir_rx = 0;
        drive(0, 0, 0, 0, 0, 0, 1);
        chk("R5 zero length", int'(xfer_busy), 0);
        // transmit of 10 bytes, threshold 4
        xfer_len = 10;
        drive(0, 0, 0, 0, 0, 0, 1);
        chk("R5 start tx", int'(xfer_busy), 1);
        xfer_len = 3; dir_rx = 1;
        drive(0, 0, 0, 0, 0, 0, 1); // ignored, busy
        idle(2);
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < 4; i++) drive(1, 0, 0, 0, 0, 0, 0);
            for (int i = 0; i < 4; i++) drive(0, 1, 0, 0, 0, 0, 0);
            idle(2);
        end
        for (int i = 0; i < 2; i++) drive(1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 2; i++) drive(0, 1, 0, 0, 0, 0, 0);
        idle(2);
        chk("R6 R11 tx complete", int'(xfer_busy), 0);
        // receive of 7 bytes, threshold 3
        xfer_len = 7; dir_rx = 1;
        drive(0, 0, 0, 0, 0, 0, 1);
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < 3; i++) drive(0, 0, 1, 0, 0, 0, 0);
            idle(2);
            for (int i = 0; i < 3; i++) drive(0, 0, 0, 1, 0, 0, 0);
        end
        drive(0, 0, 1, 0, 0, 0, 0);
        idle(3);
        chk("R11 rx waits for drain", int'(xfer_busy), 1);
        drive(0, 0, 0, 1, 0, 0, 0);
        idle(2);
        chk("R11 rx complete", int'(xfer_busy), 0);
        // R2 other fields: tx threshold 1, rx threshold 64
        thresh_cfg = 16'h3F00;
        xfer_len = 2; dir_rx = 1;
        drive(0, 0, 0, 0, 0, 0, 1);
        drive(0, 0, 1, 0, 0, 0, 0);
        drive(0, 0, 1, 0, 0, 0, 0);
        idle(3);
        drive(0, 0, 0, 1, 0, 0, 0);
        drive(0, 0, 0, 1, 0, 0, 0);
        idle(2);
        xfer_len = 3; dir_rx = 0;
        drive(0, 0, 0, 0, 0, 0, 1);
        for (int i = 0; i < 3; i++) begin
            drive(1, 0, 0, 0, 0, 0, 0);
            drive(0, 1, 0, 0, 0, 0, 0);
            idle(1);
        end
        idle(3);
        // mixed pseudo-random phase, threshold fixed
        thresh_cfg = 16'h0402;
        r = 32'h1234_5678;
        for (int c = 0; c < 3000; c++) begin
            r = r * 1103515245 + 12345;
            xfer_len = 16'(((r >>> 4) & 31));
            dir_rx = r[9];
            drive(r[16], r[17], r[18], r[19], ((r >>> 20) & 63) == 0,
                  ((r >>> 26) & 63) == 0, ((r >>> 11) & 7) == 0);
        end
        idle(4);
        chk("R7 tx ready seen", int'(seen_tr > 0), 1);
        chk("R8 tx drain seen", int'(seen_td > 0), 1);
        chk("R9 rx ready seen", int'(seen_rr > 0), 1);
        chk("R10 rx drain seen", int'(seen_rd > 0), 1);
        finish_run();
    end
endmodule